// File: doc/BRIEF.md
# I2C Register Transaction Controller

This block is a single-master I2C controller that runs whole register accesses for a simple command port. A command carries a 7-bit target address, an 8-bit register index, a direction flag and a byte count. The controller then drives the bus through the full register-pointer sequence on its own. It first writes the index. For a read it follows this with a repeated START and a burst read, so the client never handles individual bus conditions.

Write bytes are pulled from the client over a valid/ready handshake, and received bytes are offered on a second valid/ready handshake. When the client is slow on either side, the controller holds SCL low and waits. Both bus lines are modelled as open-drain. The block only produces drive-low enables, and a released line reads high through an external pull-up. The status outputs are busy, a one-cycle done and a sticky error flag.

Top module: `i2c_reg_master`

## Requirements
- R1: While SCL is released (high), SDA may fall only as a START and may rise only as a STOP. Every other SDA change happens with SCL held low. A write has exactly one START and one STOP. A read has two STARTs (the second is a repeated START) and one STOP.
- R2: A write command sends, in this order: address with R/W=0, the register index, then `cmd_len` data bytes, all MSB first. The target ends up holding each byte at consecutive register indices.
- R3: A read command sends address with R/W=0, then the register index, a repeated START, and address with R/W=1. It then shifts in `cmd_len` bytes MSB first and presents them on `rd_data` in bus order.
- R4: During a read, the controller drives SDA low (ACK) in the ninth clock of every received byte except the last. For the last byte it leaves SDA released (NAK) and then issues STOP.
- R5: After each byte the controller sends, it releases SDA for the ninth clock and samples SDA while SCL is high. If it reads high (no acknowledge), `error` is set, no further byte is sent, STOP is issued and the controller returns to idle. `error` stays set until the next command is accepted.
- R6: `cmd_ready` is high exactly when the controller is idle (`busy` low). A command is taken on `cmd_valid && cmd_ready`, and `cmd_valid` while busy has no effect.
- R7: `done` is high for exactly one cycle, right after the final STOP completes. In that cycle `busy` is low and both lines are released.
- R8: While waiting for `wr_valid`, or for `rd_ready` while `rd_valid` is high, SCL is held low and SDA is released. `rd_data` is held stable until it is accepted.
- R9: Each SCL bit lasts 4*DIV system clocks: two quarter-bits low and two quarter-bits high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_addr | input | 7 | Target device address |
| cmd_reg | input | 8 | Register index to write first |
| cmd_read | input | 1 | 1 = read transaction, 0 = write |
| cmd_len | input | LENW | Number of data bytes (0 is taken as 1) |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Controller wants the next write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Received byte available |
| rd_ready | input | 1 | Client takes the received byte |
| rd_data | output | 8 | Received byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse after final STOP |
| error | output | 1 | Missing acknowledge seen in last transaction |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Resolved SDA line level |

## Verification
The assertions watch on every cycle that SDA changes under a high SCL only as a START or STOP, and that a command handshake makes the controller busy. They also check that done is a single bus-released pulse, that a stall keeps SCL low with read data stable, and that an error appears only together with STOP. Whether the right bytes reach the right registers, whether a burst read ACKs all but its last byte, and whether a missing acknowledge cuts the write short can only be shown by the bench's target model and its scenarios. The same holds for the measured SCL bit period.

// File: rtl/i2c_reg_master.sv
module i2c_reg_master #(
  parameter int DIV  = 125,
  parameter int LENW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [6:0]      cmd_addr,
  input  logic [7:0]      cmd_reg,
  input  logic            cmd_read,
  input  logic [LENW-1:0] cmd_len,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [7:0]      wr_data,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [7:0]      rd_data,
  output logic            busy,
  output logic            done,
  output logic            error,
  output logic            scl_oe,
  output logic            sda_oe,
  input  logic            sda_in
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  typedef enum logic [2:0] {M_IDLE, M_START, M_XFER, M_STOP, M_WWAIT, M_RWAIT} mode_t;
  typedef enum logic [2:0] {S_AW, S_REG, S_AR, S_WD, S_RD} step_t;

  mode_t           mode;
  step_t           step;
  logic [CW-1:0]   qcnt;
  logic [1:0]      phase;
  logic [3:0]      bitn;
  logic [7:0]      shreg;
  logic [6:0]      addr_q;
  logic [7:0]      reg_q;
  logic            rd_q, rep, nak, ack_bad, err, done_q;
  logic [LENW-1:0] left;

  wire run      = (mode == M_START) || (mode == M_XFER) || (mode == M_STOP);
  wire tick     = run && (qcnt == CW'(DIV - 1));
  wire slot_end = tick && (phase == 2'd3);
  wire rx       = (step == S_RD);
  wire last     = (left == LENW'(1));

  assign cmd_ready = (mode == M_IDLE);
  assign busy      = (mode != M_IDLE);
  assign wr_ready  = (mode == M_WWAIT);
  assign rd_valid  = (mode == M_RWAIT);
  assign rd_data   = shreg;
  assign done      = done_q;
  assign error     = err;

  always_comb begin
    case (mode)
      M_START: begin scl_oe = (phase == 2'd3) || (phase == 2'd0 && rep); sda_oe = phase[1]; end
      M_XFER:  begin
        scl_oe = (phase == 2'd0) || (phase == 2'd3);
        sda_oe = (bitn == 4'd8) ? (rx && !nak) : (!rx && !shreg[7]);
      end
      M_STOP:  begin scl_oe = (phase == 2'd0); sda_oe = !phase[1]; end
      M_WWAIT, M_RWAIT: begin scl_oe = 1'b1; sda_oe = 1'b0; end
      default: begin scl_oe = 1'b0; sda_oe = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_IDLE; step <= S_AW; qcnt <= '0; phase <= 2'd0; bitn <= 4'd0;
      shreg <= 8'd0; addr_q <= 7'd0; reg_q <= 8'd0; rd_q <= 1'b0; rep <= 1'b0;
      nak <= 1'b0; ack_bad <= 1'b0; err <= 1'b0; done_q <= 1'b0; left <= '0;
    end else begin
      done_q <= 1'b0;
      if (run) begin
        if (tick) begin qcnt <= '0; phase <= phase + 2'd1; end
        else qcnt <= qcnt + CW'(1);
      end
      case (mode)
        M_IDLE: if (cmd_valid) begin
          mode   <= M_START;
          step   <= S_AW;
          rep    <= 1'b0;
          err    <= 1'b0;
          shreg  <= {cmd_addr, 1'b0};
          addr_q <= cmd_addr;
          reg_q  <= cmd_reg;
          rd_q   <= cmd_read;
          left   <= (cmd_len == '0) ? LENW'(1) : cmd_len;
        end
        M_START: if (slot_end) begin mode <= M_XFER; bitn <= 4'd0; end
        M_XFER: begin
          if (tick && phase == 2'd1) begin
            if (bitn == 4'd8) ack_bad <= sda_in;
            else if (rx) shreg <= {shreg[6:0], sda_in};
          end
          if (slot_end) begin
            if (bitn < 4'd8) begin
              if (!rx) shreg <= {shreg[6:0], 1'b0};
              if (rx && bitn == 4'd7) mode <= M_RWAIT;
              else bitn <= bitn + 4'd1;
            end else if (rx) begin
              if (last) mode <= M_STOP;
              else begin left <= left - LENW'(1); bitn <= 4'd0; end
            end else if (ack_bad) begin
              err  <= 1'b1;
              mode <= M_STOP;
            end else begin
              case (step)
                S_AW: begin step <= S_REG; shreg <= reg_q; bitn <= 4'd0; end
                S_REG: if (rd_q) begin
                  step <= S_AR; mode <= M_START; rep <= 1'b1; shreg <= {addr_q, 1'b1};
                end else begin
                  step <= S_WD; mode <= M_WWAIT;
                end
                S_AR: begin step <= S_RD; bitn <= 4'd0; end
                default: if (last) mode <= M_STOP;
                         else begin left <= left - LENW'(1); mode <= M_WWAIT; end
              endcase
            end
          end
        end
        M_WWAIT: if (wr_valid) begin shreg <= wr_data; bitn <= 4'd0; mode <= M_XFER; end
        M_RWAIT: if (rd_ready) begin bitn <= 4'd8; nak <= last; mode <= M_XFER; end
        M_STOP: if (slot_end) begin mode <= M_IDLE; done_q <= 1'b1; end
        default: mode <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_reg_master_chk.sv
module i2c_reg_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       busy,
  input logic       done,
  input logic       error,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       wr_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       in_start,
  input logic       in_stop
);
  p_sda_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |->
      ((in_start && sda_oe) || (in_stop && !sda_oe)));

  p_error_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> in_stop);

  p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (busy && !cmd_ready));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !scl_oe && !sda_oe));

  p_stall_scl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready || rd_valid) |-> (scl_oe && !sda_oe));

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

bind i2c_reg_master i2c_reg_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .busy(busy), .done(done), .error(error), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .in_start(mode == M_START), .in_stop(mode == M_STOP)
);

// File: tb/i2c_reg_master_test.sv
module i2c_reg_master_test;
  localparam int DIV = 3;
  localparam logic [6:0] TADDR = 7'h1D;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_read = 1'b0;
  logic [6:0] cmd_addr = 7'd0;
  logic [7:0] cmd_reg = 8'd0, cmd_len = 8'd0;
  logic wr_valid = 1'b0, rd_ready = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic cmd_ready, wr_ready, rd_valid, busy, done, error, scl_oe, sda_oe;
  logic [7:0] rd_data;
  logic tdrv = 1'b0;
  wire scl = !scl_oe;
  wire sda = !(sda_oe || tdrv);

  i2c_reg_master #(.DIV(DIV), .LENW(8)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_reg(cmd_reg), .cmd_read(cmd_read), .cmd_len(cmd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .done(done), .error(error), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sda_in(sda)
  );

  int vectors = 0, fails = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 7 + 3);
  endfunction

  logic [7:0] mem [256];
  logic [7:0] sh = 8'd0, txb = 8'd0;
  int bitc = 0, bidx = 0, ptr = 0, nak_at = -1;
  bit active = 0, trw = 0, txon = 0;
  logic ps = 1'b1, pd = 1'b1;
  int starts = 0, stops = 0, macks = 0, mnaks = 0, dones = 0;
  int cyc = 0, last_rise = 0, gap_n = 0, gap_bad = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) chk("R6 ready_vs_busy", cmd_ready, !busy);
    if (done) dones++;
    if (ps && scl && pd && !sda) begin
      starts++; active = 1; bitc = -1; bidx = 0; txon = 1; tdrv <= 1'b0;
    end else if (ps && scl && !pd && sda) begin
      stops++; active = 0; tdrv <= 1'b0;
    end else if (!ps && scl && active) begin
      if (bitc >= 1 && bitc <= 7) begin
        gap_n++;
        if (cyc - last_rise != 4 * DIV) gap_bad++;
      end
      last_rise = cyc;
      if (bitc == 8) begin
        if (trw && bidx > 0) begin
          if (sda) begin mnaks++; txon = 0; end else macks++;
        end
      end else if (!(trw && bidx > 0)) sh = {sh[6:0], sda};
    end else if (ps && !scl && active) begin
      bitc++;
      if (bitc == 8) begin
        if (bidx == 0) begin
          trw = sh[0];
          if (sh[7:1] == TADDR) tdrv <= 1'b1;
          else begin active = 0; tdrv <= 1'b0; end
        end else if (trw) tdrv <= 1'b0;
        else begin
          if (bidx == 1) ptr = int'(sh);
          else begin mem[ptr] = sh; ptr = (ptr + 1) & 255; end
          tdrv <= (nak_at != bidx);
        end
      end else if (bitc == 9) begin
        bitc = 0; bidx++;
        if (trw && txon) begin
          txb = mem[ptr]; ptr = (ptr + 1) & 255; tdrv <= !txb[7];
        end else tdrv <= 1'b0;
      end else if (trw && bidx > 0 && txon && bitc >= 1) tdrv <= !txb[7 - bitc];
    end
    ps = scl; pd = sda;
  end

  logic [7:0] wq[$];
  logic [7:0] rq[$];
  int wr_gap = 0, wr_wait = 0, rd_gap = 0, rd_wait = 0;
  always @(negedge clk) begin
    if (wr_ready) wr_wait++;
    wr_valid = (wq.size() > 0) && (wr_wait > wr_gap);
    wr_data  = (wq.size() > 0) ? wq[0] : 8'd0;
    if (wr_valid && wr_ready) begin void'(wq.pop_front()); wr_wait = 0; end
    if (rd_valid) rd_wait++; else rd_wait = 0;
    rd_ready = rd_valid && (rd_wait > rd_gap);
    if (rd_valid && rd_ready) rq.push_back(rd_data);
  end

  task automatic clear_counts();
    starts = 0; stops = 0; macks = 0; mnaks = 0; dones = 0; rq.delete();
  endtask

  task automatic run_cmd(input logic [6:0] a, input logic [7:0] r, input logic rd, input int n);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_addr = a; cmd_reg = r; cmd_read = rd; cmd_len = 8'(n); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    repeat (4) @(negedge clk);
    chk("R6 reset busy", busy, 0);
    chk("R6 reset cmd_ready", cmd_ready, 1);
    chk("R7 reset done", done, 0);
    chk("R1 reset scl released", scl_oe, 0);
    chk("R1 reset sda released", sda_oe, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    clear_counts();
    wq.push_back(8'hA5);
    run_cmd(TADDR, 8'h10, 1'b0, 1);
    chk("R2 single write stored", mem[8'h10], 8'hA5);
    chk("R2 single write no error", error, 0);
    chk("R1 write starts", starts, 1);
    chk("R1 write stops", stops, 1);
    chk("R7 write done count", dones, 1);

    clear_counts();
    wr_gap = 6;
    wq.push_back(8'h3C); wq.push_back(8'hC3); wq.push_back(8'h5A);
    run_cmd(TADDR, 8'h20, 1'b0, 3);
    chk("R8 stalled burst write byte0", mem[8'h20], 8'h3C);
    chk("R2 burst write byte1", mem[8'h21], 8'hC3);
    chk("R2 burst write byte2", mem[8'h22], 8'h5A);
    chk("R8 write queue drained", wq.size(), 0);
    wr_gap = 0;

    clear_counts();
    run_cmd(TADDR, 8'h10, 1'b1, 1);
    chk("R3 single read count", rq.size(), 1);
    chk("R3 single read data", (rq.size() > 0) ? rq[0] : 8'hXX, 8'hA5);
    chk("R1 read starts incl repeated", starts, 2);
    chk("R1 read stops", stops, 1);
    chk("R4 single read master acks", macks, 0);
    chk("R4 single read master naks", mnaks, 1);

    clear_counts();
    rd_gap = 5;
    run_cmd(TADDR, 8'h40, 1'b1, 4);
    chk("R8 burst read count", rq.size(), 4);
    for (int i = 0; i < 4; i++)
      chk("R3 burst read data", (rq.size() > i) ? rq[i] : 8'hXX, init_val(8'h40 + i));
    chk("R4 burst read master acks", macks, 3);
    chk("R4 burst read master naks", mnaks, 1);
    rd_gap = 0;

    clear_counts();
    wq.push_back(8'h77);
    run_cmd(7'h1C, 8'h30, 1'b0, 1);
    chk("R5 wrong address error", error, 1);
    chk("R5 wrong address stop", stops, 1);
    chk("R5 wrong address done", dones, 1);
    chk("R5 wrong address data not taken", wq.size(), 1);
    chk("R5 wrong address reg untouched", mem[8'h30], init_val(8'h30));
    wq.delete();

    clear_counts();
    nak_at = 2;
    wq.push_back(8'h11); wq.push_back(8'h22);
    run_cmd(TADDR, 8'h50, 1'b0, 2);
    chk("R5 data nak error", error, 1);
    chk("R5 data nak second byte not sent", wq.size(), 1);
    chk("R5 data nak single stop", stops, 1);
    chk("R5 data nak next reg untouched", mem[8'h51], init_val(8'h51));
    wq.delete();
    nak_at = -1;

    clear_counts();
    fork
      run_cmd(TADDR, 8'h10, 1'b1, 2);
      begin
        repeat (60) @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = TADDR; cmd_reg = 8'h77; cmd_read = 1'b0;
        repeat (20) @(negedge clk);
        cmd_valid = 1'b0;
      end
    join
    chk("R6 busy command ignored starts", starts, 2);
    chk("R6 busy command ignored done", dones, 1);
    chk("R5 error cleared by new command", error, 0);
    chk("R3 read after busy data0", (rq.size() > 0) ? rq[0] : 8'hXX, 8'hA5);
    chk("R3 read after busy data1", (rq.size() > 1) ? rq[1] : 8'hXX, init_val(8'h11));
    repeat (20) @(negedge clk);
    chk("R6 stays idle", busy, 0);

    chk("R9 bit periods measured", (gap_n > 0) ? 1 : 0, 1);
    chk("R9 bit period mismatches", gap_bad, 0);
    finish_run();
  end
endmodule